// File: doc/BRIEF.md
# Up/Down Reload-Capture Timer

This block is a 16-bit counter with three operating modes, chosen through a control register. In reload mode it counts up or down. When it wraps, it reloads itself from a companion register, and an external trigger pin can force the same reload. In capture mode it counts up freely, and a falling edge on the trigger pin snapshots the count into that companion register. In baud mode it ignores the other mode bits and steps at half the clock rate. Each wrap in baud mode emits a one-cycle tick that a serial unit can use as its bit clock.

The count source is either a prescaled clock or the falling edges of a count-input pin. Both pins pass through a synchronizer before their edges are detected, so each falling edge acts exactly once. Software reaches the block through a flat write port and a combinational read port. A sticky overflow flag records wraps in reload and capture modes.

Top module: `updown_reload_timer`

## Requirements
- R1: After reset the control register, the counter and the reload/capture register all read 0, and `baud_tick` is low.
- R2: Address 0 is the control register and address 1 is the counter. Address 2 is the reload/capture register, and address 3 reads 0. Control bits:
  - bit 0: run.
  - bit 1: event source (1 counts count-pin edges).
  - bit 2: capture mode.
  - bit 3: external enable.
  - bit 4: count down.
  - bit 5: transmit baud select.
  - bit 6: receive baud select.
  - bit 7: overflow flag, read-only through writes that clear it.
  
  A register write overrides any count update in the same cycle.
- R3: With event source 0 and run set, the counter steps once per PRESCALE clock cycles. The prescaler restarts when run is cleared.
- R4: With event source 1 and run set, the counter steps once per synchronized falling edge of `cnt_pin`. A steady pin causes no steps.
- R5: In reload mode counting up, a step taken at 16'hFFFF loads the reload value and sets the overflow flag.
- R6: In reload mode with the down bit set, a step taken while the count equals the reload value loads 16'hFFFF and sets the flag. Any other down step decrements, and 0 becomes 16'hFFFF without setting the flag.
- R7: In reload mode with external enable set, each falling edge of `trig_pin` loads the reload value into the counter once, whether or not run is set. With external enable clear, the pin has no effect.
- R8: In capture mode the counter counts up regardless of the down bit. A step at 16'hFFFF wraps to 0 and sets the flag, and the reload register is never loaded into the counter.
- R9: In capture mode with external enable set, a falling edge of `trig_pin` copies the counter into the capture register once. The register is otherwise held, and rising edges do nothing.
- R10: Either baud select bit forces baud mode while run is set:
  - The counter steps up once every two clock cycles, ignoring the source, capture and down bits.
  - A step at 16'hFFFF loads the reload value and drives `baud_tick` high for exactly the next cycle.
  - The overflow flag is untouched, and `trig_pin` edges are ignored.
- R11: The overflow flag stays set until a control write with bit 7 = 1. Other control writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| cnt_pin | input | 1 | Count-input pin for event counting |
| trig_pin | input | 1 | External reload/capture trigger pin |
| baud_tick | output | 1 | One-cycle pulse on each baud-mode wrap |

## Verification
The assertions check the following on every cycle:
- The flag only clears on a clear write, and it never rises out of baud mode.
- `baud_tick` never lasts two cycles and only follows baud mode.
- The capture register only moves on a write or a trigger edge.
- Counter writes land exactly.
- The wrap values in the up, down and capture cases are correct.

Only the bench scenarios can show the step rates of the prescaler, the half-rate baud clock and the event input. The same holds for the exact count after a run of random length, for the once-per-edge behaviour of the trigger pin, and for the cases where the pin must have no effect.

// File: rtl/urt_pkg.sv
package urt_pkg;

  // Register addresses of the flat access port
  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_COUNT = 2'd1,
    RA_RCAP  = 2'd2,
    RA_NONE  = 2'd3
  } urt_addr_e;

  // Writable configuration bits, run at bit 0
  typedef struct packed {
    logic rx_baud;
    logic tx_baud;
    logic down;
    logic ext_en;
    logic cap_mode;
    logic evt_src;
    logic run;
  } urt_cfg_t;

  localparam int unsigned CFG_W = $bits(urt_cfg_t);

endpackage

// File: rtl/urt_edge_sync.sv
module urt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);

  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q, prev_d;

  always_comb begin
    sh_d[0] = pin;
    for (int i = 1; i < STAGES; i++) sh_d[i] = sh_q[i-1];
    prev_d = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  // one pulse per high-to-low change of the synchronized level
  assign fall = prev_q & ~sh_q[STAGES-1];

endmodule

// File: rtl/urt_step_gen.sv
module urt_step_gen #(
  parameter int unsigned PRESCALE = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic evt_src,
  input  logic baud_mode,
  input  logic evt_fall,
  output logic step
);

  logic half_q, half_d;
  logic pre_tick;

  // half-rate enable for baud mode
  always_comb half_d = run & baud_mode & ~half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign pre_tick = run;
    end else begin : g_div
      localparam int unsigned PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pre_q, pre_d;
      logic          pre_en;

      always_comb begin
        pre_en = run & ~baud_mode;
        if (!pre_en)           pre_d = '0;
        else if (pre_q == LAST) pre_d = '0;
        else                   pre_d = pre_q + PW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign pre_tick = pre_en & (pre_q == LAST);
    end
  endgenerate

  always_comb begin
    if (baud_mode)    step = run & half_q;
    else if (evt_src) step = run & evt_fall;
    else              step = pre_tick;
  end

endmodule

// File: rtl/urt_core.sv
module urt_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             cap_mode,
  input  logic             down,
  input  logic             ext_en,
  input  logic             baud_mode,
  input  logic             trig_fall,
  input  logic             wr_cnt,
  input  logic             wr_rcap,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rcap_q,
  output logic             ovf_set,
  output logic             baud_tick
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d, rcap_d;
  logic             tick_d;
  logic             at_top, at_rel, ext_hit;

  always_comb begin
    at_top  = (cnt_q == CNT_MAX);
    at_rel  = (cnt_q == rcap_q);
    ext_hit = trig_fall & ext_en & ~baud_mode;
    cnt_d   = cnt_q;
    rcap_d  = rcap_q;
    ovf_set = 1'b0;
    tick_d  = 1'b0;

    if (baud_mode) begin
      if (step) begin
        if (at_top) begin
          cnt_d  = rcap_q;
          tick_d = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
    end else if (cap_mode) begin
      if (step) begin
        cnt_d   = cnt_q + ONE;
        ovf_set = at_top;
      end
      if (ext_hit) rcap_d = cnt_q;
    end else begin
      if (ext_hit) begin
        cnt_d = rcap_q;
      end else if (step) begin
        if (down) begin
          if (at_rel) begin
            cnt_d   = CNT_MAX;
            ovf_set = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end else if (at_top) begin
          cnt_d   = rcap_q;
          ovf_set = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
    end

    if (wr_cnt)  cnt_d  = wr_data;
    if (wr_rcap) rcap_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rcap_q    <= '0;
      baud_tick <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      rcap_q    <= rcap_d;
      baud_tick <= tick_d;
    end
  end

endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer
  import urt_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PRESCALE    = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             cnt_pin,
  input  logic             trig_pin,
  output logic             baud_tick
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_int_n = rst_sh_q[1];

  urt_cfg_t         cfg_q, cfg_d;
  logic             ovf_q, ovf_d;
  logic             wr_ctrl, wr_cnt, wr_rcap;
  logic             baud_mode;
  logic             cnt_fall, trig_fall, step_w, ovf_set;
  logic [CNT_W-1:0] cnt_w, rcap_w;

  always_comb begin
    wr_ctrl   = wr_en && (wr_addr == RA_CTRL);
    wr_cnt    = wr_en && (wr_addr == RA_COUNT);
    wr_rcap   = wr_en && (wr_addr == RA_RCAP);
    baud_mode = cfg_q.tx_baud | cfg_q.rx_baud;
    cfg_d     = wr_ctrl ? urt_cfg_t'(wr_data[CFG_W-1:0]) : cfg_q;
    // clear on write-one, a new wrap in the same cycle wins
    ovf_d     = (ovf_q & ~(wr_ctrl & wr_data[CFG_W])) | ovf_set;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      ovf_q <= ovf_d;
    end
  end

  urt_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk (clk),
    .rst_n (rst_int_n),
    .pin (cnt_pin),
    .fall (cnt_fall)
  );

  urt_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk (clk),
    .rst_n (rst_int_n),
    .pin (trig_pin),
    .fall (trig_fall)
  );

  urt_step_gen #(.PRESCALE(PRESCALE)) u_step (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (cfg_q.run),
    .evt_src   (cfg_q.evt_src),
    .baud_mode (baud_mode),
    .evt_fall  (cnt_fall),
    .step      (step_w)
  );

  urt_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .step      (step_w),
    .cap_mode  (cfg_q.cap_mode),
    .down      (cfg_q.down),
    .ext_en    (cfg_q.ext_en),
    .baud_mode (baud_mode),
    .trig_fall (trig_fall),
    .wr_cnt    (wr_cnt),
    .wr_rcap   (wr_rcap),
    .wr_data   (wr_data),
    .cnt_q     (cnt_w),
    .rcap_q    (rcap_w),
    .ovf_set   (ovf_set),
    .baud_tick (baud_tick)
  );

  always_comb begin
    case (rd_addr)
      RA_CTRL:  rd_data = CNT_W'({ovf_q, cfg_q});
      RA_COUNT: rd_data = cnt_w;
      RA_RCAP:  rd_data = rcap_w;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/urt_checker.sv
module urt_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic             baud_tick,
  input logic             ovf,
  input logic             baud_mode,
  input logic             cap_mode,
  input logic             down,
  input logic             ext_en,
  input logic             step,
  input logic             trig_fall,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rcap
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $fell(ovf) |-> $past(wr_en && wr_addr == 2'd0 && wr_data[7])); // R11

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && baud_tick |=> !baud_tick); // R10

  AST_TICK_IN_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && baud_tick |-> $past(baud_mode)); // R10

  AST_BAUD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(ovf) |-> !$past(baud_mode)); // R10

  AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wr_en && wr_addr == 2'd1) |-> cnt == $past(wr_data)); // R2

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!(wr_en && wr_addr == 2'd2) && !trig_fall) |-> $stable(rcap)); // R9

  AST_UP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(step && !baud_mode && !cap_mode && !down && cnt == CNT_MAX
                     && !(trig_fall && ext_en) && !wr_en)
    |-> (cnt == $past(rcap)) && ovf); // R5

  AST_DOWN_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(step && !baud_mode && !cap_mode && down && cnt == rcap
                     && !(trig_fall && ext_en) && !wr_en)
    |-> (cnt == CNT_MAX) && ovf); // R6

  AST_CAP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(step && !baud_mode && cap_mode && cnt == CNT_MAX && !wr_en)
    |-> (cnt == '0) && ovf); // R8

endmodule

bind updown_reload_timer urt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .baud_tick (baud_tick),
  .ovf       (ovf_q),
  .baud_mode (baud_mode),
  .cap_mode  (cfg_q.cap_mode),
  .down      (cfg_q.down),
  .ext_en    (cfg_q.ext_en),
  .step      (step_w),
  .trig_fall (trig_fall),
  .cnt       (cnt_w),
  .rcap      (rcap_w)
);

// File: tb/sim_updown_reload_timer.sv
module sim_updown_reload_timer;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic        cnt_pin;
  logic        trig_pin;
  logic        baud_tick;

  int n_tests = 0;
  int n_fail  = 0;
  int tick_total = 0;
  bit done = 0;

  // control bit values, see R2
  localparam logic [15:0] B_RUN  = 16'h0001;
  localparam logic [15:0] B_EVT  = 16'h0002;
  localparam logic [15:0] B_CAP  = 16'h0004;
  localparam logic [15:0] B_EXT  = 16'h0008;
  localparam logic [15:0] B_DOWN = 16'h0010;
  localparam logic [15:0] B_TXB  = 16'h0020;
  localparam logic [15:0] B_RXB  = 16'h0040;
  localparam logic [15:0] B_CLR  = 16'h0080;
  localparam int PRE = 3;

  updown_reload_timer #(.CNT_W(16), .PRESCALE(PRE), .SYNC_STAGES(2)) u0 (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
    .cnt_pin (cnt_pin), .trig_pin (trig_pin), .baud_tick (baud_tick)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) if (baud_tick) tick_total++;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // run for exactly n clock edges with configuration c
  task automatic run_for(input logic [15:0] c, input int n);
    wr(2'd0, c | B_RUN);
    repeat (n - 1) @(negedge clk);
    wr(2'd0, c);
  endtask

  task automatic pulse_trig();
    trig_pin = 1'b0; idle(6);
    trig_pin = 1'b1; idle(6);
  endtask

  // reference stepping: mode 0 up reload, 1 down reload, 2 capture, 3 baud
  function automatic logic [15:0] model(input logic [15:0] v, input logic [15:0] r,
                                        input int mode, input int steps, output int ev);
    ev = 0;
    for (int i = 0; i < steps; i++) begin
      case (mode)
        1: if (v == r) begin v = 16'hFFFF; ev++; end else v = v - 16'd1;
        2: begin if (v == 16'hFFFF) ev++; v = v + 16'd1; end
        default: if (v == 16'hFFFF) begin v = r; ev++; end else v = v + 16'd1;
      endcase
    end
    return v;
  endfunction

  initial begin
    logic [15:0] v, r, st, exp_v, cfg;
    int n, steps, ev, t0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    cnt_pin = 1'b1; trig_pin = 1'b1;
    void'($urandom(32'h5EED_0042));
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); chk("R1 count", v, 16'h0000);
    rd(2'd2, v); chk("R1 reload", v, 16'h0000);
    chk("R1 baud_tick", {15'd0, baud_tick}, 16'h0000);

    // R2 readback and address map
    @(negedge clk);
    wr(2'd0, B_EXT | B_DOWN | B_CAP); rd(2'd0, v); chk("R2 ctrl readback", v, 16'h001C);
    @(negedge clk);
    wr(2'd1, 16'hA5C3); rd(2'd1, v); chk("R2 count write", v, 16'hA5C3);
    @(negedge clk);
    wr(2'd2, 16'h3C5A); rd(2'd2, v); chk("R2 reload write", v, 16'h3C5A);
    rd(2'd3, v); chk("R2 unused address", v, 16'h0000);

    // R3 prescaled timer: 9 edges -> 3 steps
    @(negedge clk);
    wr(2'd0, B_CLR); wr(2'd1, 16'h0000);
    run_for(16'h0000, 9); idle(3);
    rd(2'd1, v); chk("R3 prescale steps", v, 16'h0003);

    // R4 event counting on count pin
    @(negedge clk);
    wr(2'd1, 16'h0005); wr(2'd0, B_EVT | B_RUN);
    for (int k = 0; k < 4; k++) begin
      cnt_pin = 1'b0; idle(4); cnt_pin = 1'b1; idle(4);
    end
    idle(20);
    wr(2'd0, B_EVT);
    rd(2'd1, v); chk("R4 event count", v, 16'h0009);

    // R5 up reload
    @(negedge clk);
    wr(2'd0, B_CLR); wr(2'd2, 16'h1200); wr(2'd1, 16'hFFFE);
    run_for(16'h0000, 9); idle(3);
    rd(2'd1, v); chk("R5 up reload", v, 16'h1201);
    rd(2'd0, v); chk("R5 flag", {15'd0, v[7]}, 16'h0001);

    // R11 sticky flag
    @(negedge clk);
    wr(2'd0, B_DOWN); rd(2'd0, v); chk("R11 flag kept", {15'd0, v[7]}, 16'h0001);
    @(negedge clk);
    wr(2'd0, B_CLR); rd(2'd0, v); chk("R11 flag cleared", {15'd0, v[7]}, 16'h0000);

    // R6 down: underflow at reload, wrap at zero without flag
    @(negedge clk);
    wr(2'd2, 16'h0100); wr(2'd1, 16'h0101);
    run_for(B_DOWN, 9); idle(3);
    rd(2'd1, v); chk("R6 down underflow", v, 16'hFFFE);
    rd(2'd0, v); chk("R6 down flag", {15'd0, v[7]}, 16'h0001);
    @(negedge clk);
    wr(2'd0, B_CLR); wr(2'd2, 16'h8000); wr(2'd1, 16'h0001);
    run_for(B_DOWN, 9); idle(3);
    rd(2'd1, v); chk("R6 zero wrap", v, 16'hFFFE);
    rd(2'd0, v); chk("R6 zero wrap no flag", {15'd0, v[7]}, 16'h0000);

    // R7 external reload
    @(negedge clk);
    wr(2'd0, B_EXT); wr(2'd2, 16'h1234); wr(2'd1, 16'h0042);
    pulse_trig();
    rd(2'd1, v); chk("R7 ext reload", v, 16'h1234);
    @(negedge clk);
    wr(2'd0, 16'h0000); wr(2'd1, 16'h0042);
    pulse_trig();
    rd(2'd1, v); chk("R7 no ext enable", v, 16'h0042);
    @(negedge clk);
    wr(2'd2, 16'h4000); wr(2'd1, 16'h4000); wr(2'd0, B_EXT | B_RUN);
    trig_pin = 1'b0; idle(40);
    wr(2'd0, B_EXT); trig_pin = 1'b1; idle(6);
    rd(2'd1, v); chk("R7 single reload per edge", {15'd0, (v - 16'h4000) >= 16'd8}, 16'h0001);

    // R9 capture on trigger edge
    @(negedge clk);
    wr(2'd0, B_CAP | B_EXT); wr(2'd1, 16'hBEEF);
    pulse_trig();
    rd(2'd2, v); chk("R9 capture", v, 16'hBEEF);
    @(negedge clk);
    wr(2'd1, 16'h1111); trig_pin = 1'b0; idle(3); trig_pin = 1'b1; idle(6);
    rd(2'd2, v); chk("R9 second edge", v, 16'h1111);
    wr(2'd1, 16'h2222); idle(10);
    rd(2'd2, v); chk("R9 held no edge", v, 16'h1111);
    @(negedge clk);
    wr(2'd0, B_CAP); pulse_trig();
    rd(2'd2, v); chk("R9 no ext enable", v, 16'h1111);

    // R10 baud mode ignores trigger edges
    @(negedge clk);
    wr(2'd0, B_TXB | B_EXT); wr(2'd2, 16'h7777); wr(2'd1, 16'h0100);
    pulse_trig();
    rd(2'd1, v); chk("R10 trig ignored", v, 16'h0100);

    // random rounds across all modes
    for (int rnd = 0; rnd < 24; rnd++) begin
      int mode;
      mode = rnd % 4;
      r  = 16'($urandom);
      if (mode == 3) r = 16'hFFFF - 16'($urandom % 8);
      if (mode == 1) st = r + 16'($urandom % 20);
      else           st = 16'hFFFF - 16'($urandom % 20);
      n = 10 + int'($urandom % 50);
      steps = (mode == 3) ? n / 2 : n / PRE;
      case (mode)
        0: cfg = 16'h0000;
        1: cfg = B_DOWN;
        2: cfg = B_CAP | B_DOWN;
        default: cfg = ((rnd / 4) % 2 == 0) ? (B_TXB | B_CAP | B_DOWN) : (B_RXB | B_EVT);
      endcase
      exp_v = model(st, r, mode, steps, ev);
      @(negedge clk);
      wr(2'd0, B_CLR); wr(2'd2, r); wr(2'd1, st);
      t0 = tick_total;
      run_for(cfg, n); idle(4);
      rd(2'd1, v);
      case (mode)
        0: chk("R5 random up count", v, exp_v);
        1: chk("R6 random down count", v, exp_v);
        2: chk("R8 random capture count", v, exp_v);
        default: chk("R10 random baud count", v, exp_v);
      endcase
      rd(2'd0, v);
      if (mode == 3) begin
        chk("R10 baud flag untouched", {15'd0, v[7]}, 16'h0000);
        chk("R10 baud ticks", 16'(tick_total - t0), 16'(ev));
      end else if (mode == 2) begin
        chk("R8 capture flag", {15'd0, v[7]}, {15'd0, ev > 0});
        rd(2'd2, v); chk("R8 reload reg kept", v, r);
      end else begin
        chk("R5 R6 reload flag", {15'd0, v[7]}, {15'd0, ev > 0});
      end
    end

    done = 1;
    summary();
  end

endmodule